// File: doc/BRIEF.md
# Status-Flag Condition Gate

This unit decides, in the same cycle, whether a 32-bit instruction is allowed to run. It reads the four-bit condition field in the top of the instruction word and the four status flags (negative, zero, carry, overflow). Each of the sixteen condition codes owns a sixteen-bit truth mask. The flags are packed into a four-bit index, and the mask bit at that index is the verdict. No per-condition Boolean network is built.

Code 15 has an all-zero mask, so it never passes. That slot is reused for one case. When the check fails and the top seven instruction bits are 1111101, the word is an immediate branch-with-link that also switches instruction set. The unit raises a separate indication for it, so the issue stage still runs that word.

The unit has no clock and holds no state. It sits between fetch and execute as a gate on issue.

Top module: `cc_gate`

## Requirements
- R1: The condition code is instruction bits 31:28, and the flag index is {N,Z,C,V} with N as bit 3 and V as bit 0. `execOk` equals bit [index] of the mask selected by the code.
- R2: Codes 0 to 7 use masks 0xF0F0 (equal), 0x0F0F (not equal), 0xCCCC (carry set), 0x3333 (carry clear), 0xFF00 (negative), 0x00FF (non-negative), 0xAAAA (overflow) and 0x5555 (no overflow).
- R3: Codes 8 to 13 use masks 0x0C0C (unsigned higher), 0xF3F3 (unsigned lower or same), 0xAA55 (signed greater or equal), 0x55AA (signed less), 0x0A05 (signed greater) and 0xF5FA (signed less or equal). Code 14 uses 0xFFFF, so it passes for every flag value.
- R4: Code 15 uses mask 0x0000, so `execOk` is 0 for every flag value.
- R5: `specBranch` is 1 exactly when the condition check fails and instruction bits 31:25 equal 1111101. Bit 24 and bits 23:0 do not affect it.
- R6: `execOk` and `specBranch` are never 1 together.
- R7: `specBranch` is 1 only when the condition code is 15. A code-15 word whose bits 27:25 differ from 101 gives 0 on both outputs.
- R8: Instruction bits 27:0 have no effect on `execOk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word; the condition code is in bits 31:28 |
| flagN | input | 1 | Negative status flag |
| flagZ | input | 1 | Zero status flag |
| flagC | input | 1 | Carry status flag |
| flagV | input | 1 | Overflow status flag |
| execOk | output | 1 | Instruction passes its condition check |
| specBranch | output | 1 | Failed check on the special immediate branch encoding |

## Verification
The unit is combinational, so any fault shows at the ports in the same evaluation as the stimulus. A wrong mask bit shows only for its own code and flag index. For that reason the bench sweeps all 256 code and flag pairs, with random filler in the low instruction bits. The reference is built from the signed and unsigned meanings of each condition, not from the mask constants. A fault in the branch-prefix decode shows as `specBranch` set for a code other than 15, or as both outputs high together. Neighbouring encodings with code 15 are driven to expose such a fault.

// File: rtl/cc_gate_pkg.sv
package cc_gate_pkg;

  localparam int CODE_W  = 4;
  localparam int FLAG_W  = 4;
  localparam int NCODES  = 1 << CODE_W;
  localparam int MASK_W  = 1 << FLAG_W;
  localparam int PFX_W   = 7;
  localparam logic [PFX_W-1:0] BRANCH_PFX = 7'b1111101;
  localparam logic [CODE_W-1:0] NEVER_CODE  = 4'd15;
  localparam logic [CODE_W-1:0] ALWAYS_CODE = 4'd14;

  // Strobes from control to datapath
  typedef struct packed {
    logic [CODE_W-1:0] condCode;
    logic              neverSlot;
    logic              branchPrefix;
  } ccStrobe_t;

  // Truth mask per condition code, indexed by {N,Z,C,V}
  function automatic logic [MASK_W-1:0] condMask(input logic [CODE_W-1:0] code);
    logic [MASK_W-1:0] m;
    case (code)
      4'd0:    m = 16'hF0F0;
      4'd1:    m = 16'h0F0F;
      4'd2:    m = 16'hCCCC;
      4'd3:    m = 16'h3333;
      4'd4:    m = 16'hFF00;
      4'd5:    m = 16'h00FF;
      4'd6:    m = 16'hAAAA;
      4'd7:    m = 16'h5555;
      4'd8:    m = 16'h0C0C;
      4'd9:    m = 16'hF3F3;
      4'd10:   m = 16'hAA55;
      4'd11:   m = 16'h55AA;
      4'd12:   m = 16'h0A05;
      4'd13:   m = 16'hF5FA;
      4'd14:   m = 16'hFFFF;
      default: m = 16'h0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cc_gate_ctrl.sv
module cc_gate_ctrl
  import cc_gate_pkg::*;
(
  input  logic [PFX_W-1:0] topBits,
  input  logic             passBit,
  output ccStrobe_t        strobe,
  output logic             execOk,
  output logic             specBranch
);

  always_comb begin
    strobe.condCode     = topBits[PFX_W-1 -: CODE_W];
    strobe.neverSlot    = (topBits[PFX_W-1 -: CODE_W] == NEVER_CODE);
    strobe.branchPrefix = (topBits == BRANCH_PFX);
  end

  assign execOk     = passBit;
  assign specBranch = !passBit && strobe.branchPrefix;

  always_comb begin
    // R6
    excl_chk: assert (!(execOk && specBranch));
    // R7
    spec_code_chk: assert (!specBranch || strobe.neverSlot);
  end

endmodule

// File: rtl/cc_gate_dp.sv
module cc_gate_dp
  import cc_gate_pkg::*;
(
  input  ccStrobe_t         strobe,
  input  logic [FLAG_W-1:0] flagIdx,
  output logic              passBit
);

  logic [MASK_W-1:0] maskBank [NCODES];
  logic [MASK_W-1:0] selMask;

  for (genvar g = 0; g < NCODES; g++) begin : g_mask
    assign maskBank[g] = condMask(CODE_W'(g));
  end

  assign selMask = maskBank[strobe.condCode];
  assign passBit = selMask[flagIdx];

  always_comb begin
    // R4
    never_chk: assert (!strobe.neverSlot || !passBit);
    // R3
    always_chk: assert (strobe.condCode != ALWAYS_CODE || passBit);
  end

endmodule

// File: rtl/cc_gate.sv
module cc_gate
  import cc_gate_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  output logic              execOk,
  output logic              specBranch
);

  localparam int PFX_LSB = INSN_W - PFX_W;

  ccStrobe_t         strobe;
  logic              passBit;
  logic [FLAG_W-1:0] flagIdx;
  logic              unusedBits;

  assign flagIdx    = {flagN, flagZ, flagC, flagV};
  assign unusedBits = ^insn[PFX_LSB-1:0];

  cc_gate_ctrl u_ctrl (
    .topBits    (insn[INSN_W-1:PFX_LSB]),
    .passBit    (passBit),
    .strobe     (strobe),
    .execOk     (execOk),
    .specBranch (specBranch)
  );

  cc_gate_dp u_dp (
    .strobe  (strobe),
    .flagIdx (flagIdx),
    .passBit (passBit)
  );

endmodule

// File: tb/sim_cc_gate.sv
module sim_cc_gate;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  expExec;
    logic  expSpec;
    string req;
  } item_t;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] insn = '0;
  logic        flagN = 0, flagZ = 0, flagC = 0, flagV = 0;
  logic        execOk, specBranch;
  item_t       sbq[$];
  int          nRun = 0, nFail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_gate u0 (.insn(insn), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
              .flagV(flagV), .execOk(execOk), .specBranch(specBranch));

  function automatic logic refPass(input logic [3:0] c, input logic n, z, cy, v);
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [31:0] w, input logic [3:0] f, input string req);
    item_t it;
    logic p;
    @(negedge clk);
    insn = w;
    {flagN, flagZ, flagC, flagV} = f;
    p = refPass(w[31:28], f[3], f[2], f[1], f[0]);
    it.expExec = p;
    it.expSpec = !p && (w[31:25] == 7'b1111101);
    it.req = req;
    sbq.push_back(it);
  endtask

  // Monitor: inputs change at negedge, outputs sampled at posedge
  initial begin
    forever begin
      @(posedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        nRun++;
        if (execOk !== it.expExec || specBranch !== it.expSpec) begin
          nFail++;
          $display("FAIL %s insn=%h flags=%b got exec=%b spec=%b exp exec=%b spec=%b",
                   it.req, insn, {flagN, flagZ, flagC, flagV},
                   execOk, specBranch, it.expExec, it.expSpec);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state: zero word, zero flags -> code 0 (equal) fails (R1)
    nRun++;
    if (execOk !== 1'b0 || specBranch !== 1'b0) begin
      nFail++;
      $display("FAIL R1 reset got exec=%b spec=%b exp exec=0 spec=0", execOk, specBranch);
    end
    // Exhaustive code x flag sweep with random filler (R1 R2 R3 R4 R8)
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] w;
        w = {c[3:0], 28'($urandom)};
        if (c < 8)       drive(w, f[3:0], "R2");
        else if (c < 15) drive(w, f[3:0], "R3");
        else             drive(w, f[3:0], "R4");
        drive({c[3:0], ~w[27:0]}, f[3:0], "R8");
      end
    end
    // Special branch encodings, bit24 both ways (R5)
    for (int f = 0; f < 16; f++) begin
      drive(32'hFA00_0000 | 32'($urandom & 32'h00FF_FFFF), f[3:0], "R5");
      drive(32'hFB00_0000 | 32'($urandom & 32'h00FF_FFFF), f[3:0], "R5");
    end
    // Code 15 with other bits 27:25 -> neither output (R7)
    for (int k = 0; k < 8; k++) begin
      if (k != 5) drive({4'hF, k[2:0], 25'($urandom)}, 4'($urandom), "R7");
    end
    // Same prefix low bits under non-15 codes never give specBranch (R6 R7)
    for (int c = 0; c < 15; c++) begin
      drive({c[3:0], 3'b101, 25'($urandom)}, 4'($urandom), "R6");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nRun++;
        nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule